// File: doc/BRIEF.md
# Strobe-Domain Write Capture Register

This block accepts single-word writes from an external microcontroller bus whose write strobe has no timing relation to the core clock. On the rising (trailing) edge of the active-low write strobe, and only while the active-low chip select is low, the word on the data bus is stored in a strobe-domain holding register. The same event flips a one-bit event toggle that also lives in the strobe domain.

The core clock domain passes the toggle through a parameterised chain of synchronizer flops. An edge register after the chain detects a change. When a change is seen, the core copies the held word into its own output register, and the ready flag rises on the same edge. The core state machine pulses an acknowledge to mark the word as consumed. This realigns the core's record of the toggle, so both sides agree again and no word is pending in either domain. Every register is written by exactly one process. The strobe side only ever flips its toggle. The core side only ever follows it, so set and clear never share a driver. If a new word arrives before the previous one was acknowledged, a sticky overrun flag is raised. The ready flag stays high and the output shows the newer word.

Top module: `strobe_capture_reg`

## Requirements
- R1: A write is taken on the rising edge of `bus_wr_n` while `bus_cs_n` is low; the word on `bus_data` at that edge later appears on `core_data`.
- R2: A strobe edge with `bus_cs_n` high is ignored: `core_ready` stays low and `core_data` keeps its previous value.
- R3: With `SYNC_STAGES` = 2, `core_ready` is still low after the second core rising edge following the strobe edge and is high after the third (latency is `SYNC_STAGES`+1 edges).
- R4: `core_data` changes only on the core edge where a new word is detected, and is stable while a word is pending.
- R5: A one-cycle high pulse on `core_ack` while `core_ready` is high drives `core_ready` low at that same core edge; it stays low until the next qualified write.
- R6: `core_ack` pulsed while `core_ready` is low has no effect on `core_ready`, `core_data` or `core_overrun`.
- R7: A new word detected while `core_ready` is high and `core_ack` is low sets `core_overrun` to 1. The flag stays at 1 until reset. `core_ready` remains high and `core_data` shows the newer word.
- R8: While `rst_n` is low, `core_ready`, `core_overrun` and `core_data` are 0, and the strobe-side toggle and holding register are cleared. After release there is no spurious `core_ready`, and the next qualified write is detected normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_cs_n | input | 1 | Active-low chip select, qualifies the strobe |
| bus_wr_n | input | 1 | Active-low write strobe; its rising edge captures |
| bus_data | input | DW | Write data from the microcontroller |
| core_clk | input | 1 | Core clock |
| core_ack | input | 1 | One-cycle pulse: current word consumed |
| core_ready | output | 1 | A captured word is waiting |
| core_data | output | DW | Captured word in the core domain |
| core_overrun | output | 1 | Sticky: a word arrived before the previous was acknowledged |

## Verification
The hardest situation to reach from the ports is a second qualified write that lands while the first word is still pending. It must arrive late enough for the first word to have been detected, but before any acknowledge. The directed sequence waits for the ready flag, withholds the acknowledge, and issues a second strobe. It then checks the overrun flag, the held ready flag and the newer data. Strobe edges are always placed between core edges, so the detection cycle is exact. Random words, random chip-select gating and stray acknowledges fill the rest of the run.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // A word is pending when the followed toggle differs from the consumed record.
  function automatic logic word_pending(input logic seen_tog, input logic took_tog);
    return seen_tog ^ took_tog;
  endfunction

  // Overrun: fresh event arrives while a word is pending and not being taken.
  function automatic logic overrun_hit(input logic evt, input logic pend, input logic ack);
    return evt & pend & ~ack;
  endfunction

endpackage

// File: rtl/scr_bus_capture.sv
module scr_bus_capture #(
  parameter int DW = 16
) (
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          cs_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] hold_data,
  output logic          evt_tog
);

  // Strobe domain: clocked by the trailing edge of the write strobe.
  always_ff @(posedge wr_n or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      evt_tog   <= 1'b0;
    end else if (!cs_n) begin
      hold_data <= din;
      evt_tog   <= ~evt_tog;
    end
  end

endmodule

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/scr_core_track.sv
module scr_core_track
  import scr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_tog,
  input  logic [DW-1:0] hold_data,
  input  logic          ack,
  output logic          ready,
  output logic [DW-1:0] data,
  output logic          overrun,
  output logic          new_evt
);

  logic last_tog;   // previous synchronized toggle value
  logic took_tog;   // toggle value of the last consumed/superseded word
  logic pend;

  assign new_evt = sync_tog ^ last_tog;
  assign pend    = word_pending(last_tog, took_tog);
  assign ready   = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tog <= 1'b0;
      took_tog <= 1'b0;
      data     <= '0;
      overrun  <= 1'b0;
    end else begin
      last_tog <= sync_tog;
      if (new_evt) data <= hold_data;
      if (new_evt || ack) took_tog <= last_tog;
      if (overrun_hit(new_evt, pend, ack)) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/strobe_capture_reg.sv
module strobe_capture_reg #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic [DW-1:0] bus_data,
  input  logic          core_clk,
  input  logic          core_ack,
  output logic          core_ready,
  output logic [DW-1:0] core_data,
  output logic          core_overrun
);

  logic [DW-1:0] hold_data;
  logic          evt_tog;
  logic          sync_tog;
  logic          new_evt;

  scr_bus_capture #(.DW(DW)) u_cap (
    .rst_n     (rst_n),
    .wr_n      (bus_wr_n),
    .cs_n      (bus_cs_n),
    .din       (bus_data),
    .hold_data (hold_data),
    .evt_tog   (evt_tog)
  );

  scr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (core_clk),
    .rst_n (rst_n),
    .d     (evt_tog),
    .q     (sync_tog)
  );

  scr_core_track #(.DW(DW)) u_core (
    .clk       (core_clk),
    .rst_n     (rst_n),
    .sync_tog  (sync_tog),
    .hold_data (hold_data),
    .ack       (core_ack),
    .ready     (core_ready),
    .data      (core_data),
    .overrun   (core_overrun),
    .new_evt   (new_evt)
  );

endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          ready,
  input logic [DW-1:0] data,
  input logic          overrun,
  input logic          new_evt
);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ack && !new_evt) |=> !ready);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (new_evt && ready && !ack) |=> overrun);

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !new_evt |=> $stable(data));

  assert_ready_from_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(new_evt));

endmodule

bind strobe_capture_reg scr_checker #(.DW(DW)) u_chk (
  .clk     (core_clk),
  .rst_n   (rst_n),
  .ack     (core_ack),
  .ready   (core_ready),
  .data    (core_data),
  .overrun (core_overrun),
  .new_evt (new_evt)
);

// File: tb/strobe_capture_reg_test.sv
module strobe_capture_reg_test;

  localparam int DW = 16;
  localparam int SYNC_STAGES = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cs_n = 1'b1;
  logic          bus_wr_n = 1'b1;
  logic [DW-1:0] bus_data = '0;
  logic          core_ack = 1'b0;
  logic          core_ready;
  logic [DW-1:0] core_data;
  logic          core_overrun;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strobe_capture_reg #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) uut (
    .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_data(bus_data),
    .core_clk(clk), .core_ack(core_ack), .core_ready(core_ready),
    .core_data(core_data), .core_overrun(core_overrun)
  );

  // Expected core edges from strobe to ready, restated from the requirement.
  function automatic int ready_latency(input int stages);
    return stages + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Strobe rising edge lands 3 ns after a falling clock edge.
  task automatic bus_write(input logic cs, input logic [DW-1:0] d);
    @(negedge clk);
    bus_cs_n = ~cs;
    bus_data = d;
    #1 bus_wr_n = 1'b0;
    #2 bus_wr_n = 1'b1;
    #1 bus_cs_n = 1'b1;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    core_ack = 1'b1;
    @(negedge clk);
    core_ack = 1'b0;
  endtask

  logic [DW-1:0] exp_data;
  logic          exp_ovr;

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    exp_data = '0;
    exp_ovr  = 1'b0;
    negs(3);
    check("R8 reset ready", core_ready, 0);
    check("R8 reset data", core_data, 0);
    check("R8 reset overrun", core_overrun, 0);
    rst_n = 1'b1;
    negs(4);
    check("R8 no spurious ready", core_ready, 0);

    // Directed: latency and capture
    bus_write(1'b1, 16'hA55A);
    negs(ready_latency(SYNC_STAGES) - 1);
    check("R3 not yet ready", core_ready, 0);
    negs(1);
    check("R3 ready at latency", core_ready, 1);
    check("R1 captured data", core_data, 16'hA55A);
    exp_data = 16'hA55A;
    pulse_ack();
    check("R5 ack clears ready", core_ready, 0);
    negs(3);
    check("R5 ready stays low", core_ready, 0);

    // Directed: deselected strobe
    bus_write(1'b0, 16'h1234);
    negs(5);
    check("R2 ignored ready", core_ready, 0);
    check("R2 ignored data", core_data, exp_data);

    // Directed: stray ack
    pulse_ack();
    negs(2);
    check("R6 stray ack ready", core_ready, 0);
    check("R6 stray ack data", core_data, exp_data);
    check("R6 stray ack overrun", core_overrun, 0);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      logic [DW-1:0] d;
      logic cs;
      d  = DW'($urandom);
      cs = ($urandom % 4) != 0;
      bus_write(cs, d);
      negs(2);
      check("R3 random early", core_ready, 0);
      negs(1);
      if (cs) begin
        exp_data = d;
        check("R1 random ready", core_ready, 1);
        check("R1 random data", core_data, exp_data);
        negs($urandom % 4);
        check("R4 data held", core_data, exp_data);
        pulse_ack();
        check("R5 random clear", core_ready, 0);
      end else begin
        negs(2);
        check("R2 random ignored", core_ready, 0);
        check("R2 random data", core_data, exp_data);
        if (($urandom % 2) == 1) begin
          pulse_ack();
          check("R6 random stray", core_ready, 0);
        end
      end
      check("R7 no overrun yet", core_overrun, exp_ovr);
      negs(1);
    end

    // Directed: overrun
    bus_write(1'b1, 16'h0F0F);
    negs(3);
    check("R1 first word", core_data, 16'h0F0F);
    bus_write(1'b1, 16'hF0F0);
    negs(2);
    check("R4 pending data held", core_data, 16'h0F0F);
    check("R7 before detection", core_overrun, 0);
    negs(1);
    check("R7 overrun set", core_overrun, 1);
    check("R7 ready held", core_ready, 1);
    check("R7 newer data", core_data, 16'hF0F0);
    pulse_ack();
    negs(3);
    check("R7 overrun sticky", core_overrun, 1);
    check("R5 clear after overrun", core_ready, 0);

    // Reset mid-run with state set
    bus_write(1'b1, 16'h7777);
    negs(3);
    check("R1 pre-reset word", core_ready, 1);
    rst_n = 1'b0;
    #1;
    check("R8 async ready", core_ready, 0);
    check("R8 async overrun", core_overrun, 0);
    check("R8 async data", core_data, 0);
    negs(2);
    rst_n = 1'b1;
    negs(4);
    check("R8 quiet after release", core_ready, 0);
    bus_write(1'b1, 16'h3C3C);
    negs(2);
    check("R8 first write early", core_ready, 0);
    negs(1);
    check("R8 first write seen", core_ready, 1);
    check("R8 first write data", core_data, 16'h3C3C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule